// File: doc/BRIEF.md
# Root Port Interrupt Status Register

This block holds the interrupt status word of a PCI Express root port. Eleven sources each own one status bit. Four of them are legacy INTx assertion message strobes. The other seven come from configuration-space enable and status bits: error reporting, power-management events, hot-plug, link bandwidth and link equalization requests. A source sets its bit when its condition is met. Software clears a bit by writing a 1 to it at the register address. The bits tied to a power-management, error or hot-plug level condition also clear themselves once that condition goes away.

The register is reached over a minimal bus with read, write, address and data lines. Read data is registered and shows up one cycle after the read strobe. A registered OR of all status bits drives one combined interrupt line. The message decoder and the configuration registers sit outside the block and only feed it strobes and levels.

Top module: `rpirq_status_top`

## Requirements
- R1: After reset every status bit is 0, a read returns 0x0000_0000 and `irq_out` is 0.
- R2: A 1 on `intx_msg[k]` (k = 0 INTA, 1 INTB, 2 INTC, 3 INTD) sets status bit k. The bit stays set until software writes 1 to it.
- R3: Bit 4 is set while any bit of `err_status` is 1 together with the same bit of `err_report_en`. It clears by itself at the first clock edge where no such pair exists.
- R4: Bit 5 is set while `intx_disable` is 0, `pme_int_en` is 1 and `pme_status` is 1. It clears by itself at the first clock edge where this is false.
- R5: Bit 6 is set while `intx_disable` is 0, `hp_int_en` is 1 and some bit of `slot_status` is 1 with the same bit of `slot_notify_en` set. It clears by itself when that condition is false.
- R6: Bit 7 is set when `pm_pme_en` is 1 and an enabled `slot_status` bit goes from 0 to 1. It clears by itself when no enabled slot status bit is 1 or `pm_pme_en` is 0. If the enabled level is still high after a write-1 clear, the bit stays 0 until a new rising edge.
- R7: Bit 8 (`lbw_int_en` and `lbw_status`) and bit 9 (`bwm_int_en` and `bwm_status`) are set when both of their inputs are 1 and `intx_disable` is 0. They stay set after the condition drops, until a write of 1.
- R8: Bit 10 is set when `leq_int_en` and `leq_req` are both 1, whatever the value of `intx_disable`. It stays set until a write of 1.
- R9: A write at `bus_addr == REG_ADDR` (default 0x40) clears each status bit whose data bit is 1. Data bits of 0 leave their status bits unchanged. Writes to other addresses change nothing.
- R10: When a bit's set condition and a write-1 clear of that bit happen in the same cycle, the bit ends up set.
- R11: Read data bits 31 to 11 are always 0.
- R12: `irq_out` is 1 exactly one cycle after a cycle in which any status bit is 1, and 0 one cycle after a cycle with all bits 0.
- R13: A read strobe at `REG_ADDR` returns the current status word on `bus_rdata` in the next cycle. In any other cycle `bus_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| intx_msg | input | 4 | INTA..INTD assertion message strobes |
| intx_disable | input | 1 | INTx assertion disable from the command register |
| err_status | input | ERR_W | Root error status bits |
| err_report_en | input | ERR_W | Matching error reporting enables |
| pme_int_en | input | 1 | PME interrupt enable |
| pme_status | input | 1 | PME status |
| hp_int_en | input | 1 | Hot-plug interrupt enable |
| slot_status | input | SLOT_W | Slot event status bits |
| slot_notify_en | input | SLOT_W | Per-event notification enables |
| pm_pme_en | input | 1 | PME enable from power-management control |
| lbw_int_en | input | 1 | Link autonomous bandwidth interrupt enable |
| lbw_status | input | 1 | Link autonomous bandwidth status |
| bwm_int_en | input | 1 | Bandwidth management interrupt enable |
| bwm_status | input | 1 | Bandwidth management status |
| leq_int_en | input | 1 | Link equalization request interrupt enable |
| leq_req | input | 1 | Link equalization request |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | DATA_W | Write data (1 bits clear) |
| bus_rdata | output | DATA_W | Registered read data |
| irq_out | output | 1 | Combined registered interrupt |

## Verification
On every cycle the assertions check that the message and sticky bits hold until a clear, that an INTA strobe always wins against a clear, and that the error bit drops one edge after its condition ends. They also check that the interrupt line follows the status word with one cycle of lag and that read data is zero when idle and zero in the reserved field. The scenarios alone show the gating by `intx_disable` and its absence on bit 10, and the edge behaviour of bit 7 when a clear lands during a steady slot level. They also show that zero data bits and writes to a foreign address have no effect.

// File: rtl/rpirq_pkg.sv
package rpirq_pkg;
   localparam int unsigned NUM_SRC  = 11;
   localparam int unsigned IDX_INTA = 0;
   localparam int unsigned IDX_ERR  = 4;
   localparam int unsigned IDX_PME  = 5;
   localparam int unsigned IDX_HP   = 6;
   localparam int unsigned IDX_HPME = 7;
   localparam int unsigned IDX_LBW  = 8;
   localparam int unsigned IDX_BWM  = 9;
   localparam int unsigned IDX_LEQ  = 10;
   // bits whose hardware condition also clears them
   localparam logic [NUM_SRC-1:0] SELF_CLR_MASK = 11'b000_1111_0000;
endpackage

// File: rtl/rpirq_cond.sv
module rpirq_cond
   import rpirq_pkg::*;
#(
   parameter int ERR_W  = 3,
   parameter int SLOT_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [3:0]        intx_msg,
   input  logic              intx_disable,
   input  logic [ERR_W-1:0]  err_status,
   input  logic [ERR_W-1:0]  err_report_en,
   input  logic              pme_int_en,
   input  logic              pme_status,
   input  logic              hp_int_en,
   input  logic [SLOT_W-1:0] slot_status,
   input  logic [SLOT_W-1:0] slot_notify_en,
   input  logic              pm_pme_en,
   input  logic              lbw_int_en,
   input  logic              lbw_status,
   input  logic              bwm_int_en,
   input  logic              bwm_status,
   input  logic              leq_int_en,
   input  logic              leq_req,
   output logic [NUM_SRC-1:0] set_vec,
   output logic [NUM_SRC-1:0] keep_vec
);
   logic [SLOT_W-1:0] slot_prev;
   logic [SLOT_W-1:0] slot_live;
   logic [SLOT_W-1:0] slot_rise;
   logic              intx_ok;
   logic              err_lvl;
   logic              pme_lvl;
   logic              hp_lvl;
   logic              hpme_lvl;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) slot_prev <= '0;
      else        slot_prev <= slot_status;
   end

   assign slot_live = slot_status & slot_notify_en;
   assign slot_rise = slot_status & ~slot_prev & slot_notify_en;
   assign intx_ok   = ~intx_disable;
   assign err_lvl   = |(err_status & err_report_en);
   assign pme_lvl   = intx_ok & pme_int_en & pme_status;
   assign hp_lvl    = intx_ok & hp_int_en & (|slot_live);
   assign hpme_lvl  = pm_pme_en & (|slot_live);

   always_comb begin
      set_vec  = '0;
      keep_vec = '1;
      set_vec[IDX_INTA +: 4] = intx_msg;
      set_vec[IDX_ERR]   = err_lvl;
      keep_vec[IDX_ERR]  = err_lvl;
      set_vec[IDX_PME]   = pme_lvl;
      keep_vec[IDX_PME]  = pme_lvl;
      set_vec[IDX_HP]    = hp_lvl;
      keep_vec[IDX_HP]   = hp_lvl;
      set_vec[IDX_HPME]  = pm_pme_en & (|slot_rise);
      keep_vec[IDX_HPME] = hpme_lvl;
      set_vec[IDX_LBW]   = intx_ok & lbw_int_en & lbw_status;
      set_vec[IDX_BWM]   = intx_ok & bwm_int_en & bwm_status;
      set_vec[IDX_LEQ]   = leq_int_en & leq_req;
   end
endmodule

// File: rtl/rpirq_bit.sv
module rpirq_bit #(
   parameter bit SELF_CLR = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic keep_i,
   input  logic clr_i,
   output logic q_o
);
   logic drop;

   generate
      if (SELF_CLR) begin : g_selfclr
         assign drop = clr_i | ~keep_i;
      end else begin : g_sticky
         logic unused_keep;
         assign unused_keep = keep_i;
         assign drop = clr_i;
      end
   endgenerate

   // set has priority over any clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q_o <= 1'b0;
      else if (set_i) q_o <= 1'b1;
      else if (drop)  q_o <= 1'b0;
   end
endmodule

// File: rtl/rpirq_bus.sv
module rpirq_bus #(
   parameter int              ADDR_W   = 8,
   parameter int              DATA_W   = 32,
   parameter logic [ADDR_W-1:0] REG_ADDR = 'h40,
   parameter int              NB       = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_rd,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic [NB-1:0]     status,
   output logic [NB-1:0]     clr_mask,
   output logic [DATA_W-1:0] bus_rdata
);
   logic              hit;
   logic [DATA_W-1:0] rd_word;

   assign hit      = (bus_addr == REG_ADDR);
   assign clr_mask = (bus_wr && hit) ? bus_wdata[NB-1:0] : '0;

   generate
      if (DATA_W > NB) begin : g_hi
         logic unused_hi;
         assign unused_hi = ^bus_wdata[DATA_W-1:NB];
      end
   endgenerate

   always_comb begin
      rd_word = '0;
      rd_word[NB-1:0] = status;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             bus_rdata <= '0;
      else if (bus_rd && hit) bus_rdata <= rd_word;
      else                    bus_rdata <= '0;
   end
endmodule

// File: rtl/rpirq_status_top.sv
module rpirq_status_top
   import rpirq_pkg::*;
#(
   parameter int                ADDR_W   = 8,
   parameter int                DATA_W   = 32,
   parameter logic [ADDR_W-1:0] REG_ADDR = 'h40,
   parameter int                ERR_W    = 3,
   parameter int                SLOT_W   = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [3:0]        intx_msg,
   input  logic              intx_disable,
   input  logic [ERR_W-1:0]  err_status,
   input  logic [ERR_W-1:0]  err_report_en,
   input  logic              pme_int_en,
   input  logic              pme_status,
   input  logic              hp_int_en,
   input  logic [SLOT_W-1:0] slot_status,
   input  logic [SLOT_W-1:0] slot_notify_en,
   input  logic              pm_pme_en,
   input  logic              lbw_int_en,
   input  logic              lbw_status,
   input  logic              bwm_int_en,
   input  logic              bwm_status,
   input  logic              leq_int_en,
   input  logic              leq_req,
   input  logic              bus_rd,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq_out
);
   localparam int NB = NUM_SRC;

   generate
      if (DATA_W < NB) begin : g_bad_data
         $error("DATA_W must hold all status bits");
      end
      if (ERR_W < 1) begin : g_bad_err
         $error("ERR_W must be at least 1");
      end
      if (SLOT_W < 1) begin : g_bad_slot
         $error("SLOT_W must be at least 1");
      end
   endgenerate

   logic [NB-1:0] set_vec;
   logic [NB-1:0] keep_vec;
   logic [NB-1:0] clr_mask;
   logic [NB-1:0] status_q;

   rpirq_cond #(.ERR_W(ERR_W), .SLOT_W(SLOT_W)) u_cond (
      .clk            (clk),
      .rst_n          (rst_n),
      .intx_msg       (intx_msg),
      .intx_disable   (intx_disable),
      .err_status     (err_status),
      .err_report_en  (err_report_en),
      .pme_int_en     (pme_int_en),
      .pme_status     (pme_status),
      .hp_int_en      (hp_int_en),
      .slot_status    (slot_status),
      .slot_notify_en (slot_notify_en),
      .pm_pme_en      (pm_pme_en),
      .lbw_int_en     (lbw_int_en),
      .lbw_status     (lbw_status),
      .bwm_int_en     (bwm_int_en),
      .bwm_status     (bwm_status),
      .leq_int_en     (leq_int_en),
      .leq_req        (leq_req),
      .set_vec        (set_vec),
      .keep_vec       (keep_vec)
   );

   generate
      for (genvar i = 0; i < NB; i++) begin : g_bit
         rpirq_bit #(.SELF_CLR(SELF_CLR_MASK[i])) u_bit (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (set_vec[i]),
            .keep_i (keep_vec[i]),
            .clr_i  (clr_mask[i]),
            .q_o    (status_q[i])
         );
      end
   endgenerate

   rpirq_bus #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_ADDR(REG_ADDR), .NB(NB)) u_bus (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_rd    (bus_rd),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .status    (status_q),
      .clr_mask  (clr_mask),
      .bus_rdata (bus_rdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_out <= 1'b0;
      else        irq_out <= |status_q;
   end
endmodule

// File: rtl/rpirq_chk.sv
module rpirq_chk
   import rpirq_pkg::*;
#(
   parameter int                ADDR_W   = 8,
   parameter int                DATA_W   = 32,
   parameter logic [ADDR_W-1:0] REG_ADDR = 'h40,
   parameter int                ERR_W    = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic [3:0]        intx_msg,
   input logic [ERR_W-1:0]  err_status,
   input logic [ERR_W-1:0]  err_report_en,
   input logic              bus_rd,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [DATA_W-1:0] bus_rdata,
   input logic [NUM_SRC-1:0] status_q,
   input logic              irq_out
);
   localparam int NB = NUM_SRC;
   logic          wr_hit;
   logic          rd_hit;
   logic [NB-1:0] clr_word;
   logic          unused_chk;

   assign wr_hit     = bus_wr && (bus_addr == REG_ADDR);
   assign rd_hit     = bus_rd && (bus_addr == REG_ADDR);
   assign clr_word   = bus_wdata[NB-1:0];
   assign unused_chk = ^{intx_msg[3:1], bus_wdata};

   generate
      for (genvar i = 0; i < NB; i++) begin : g_sticky
         if (!SELF_CLR_MASK[i]) begin : g_one
            // R2, R7, R8: sticky bits hold without a write-1 clear
            a_r2_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
               (status_q[i] && !(wr_hit && clr_word[i])) |=> status_q[i]);
         end
      end
      if (DATA_W > NB) begin : g_rsvd
         a_r11_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
            bus_rdata[DATA_W-1:NB] == '0);
      end
   endgenerate

   a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      intx_msg[0] |=> status_q[IDX_INTA]);

   a_r3_err_selfclr: assert property (@(posedge clk) disable iff (!rst_n)
      !(|(err_status & err_report_en)) |=> !status_q[IDX_ERR]);

   a_r12_irq_high: assert property (@(posedge clk) disable iff (!rst_n)
      (|status_q) |=> irq_out);

   a_r12_irq_low: assert property (@(posedge clk) disable iff (!rst_n)
      !(|status_q) |=> !irq_out);

   a_r13_rd_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_hit |=> (bus_rdata == '0));

   a_r13_rd_value: assert property (@(posedge clk) disable iff (!rst_n)
      rd_hit |=> (bus_rdata[NB-1:0] == $past(status_q)));
endmodule

bind rpirq_status_top rpirq_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_ADDR(REG_ADDR), .ERR_W(ERR_W)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .intx_msg      (intx_msg),
   .err_status    (err_status),
   .err_report_en (err_report_en),
   .bus_rd        (bus_rd),
   .bus_wr        (bus_wr),
   .bus_addr      (bus_addr),
   .bus_wdata     (bus_wdata),
   .bus_rdata     (bus_rdata),
   .status_q      (status_q),
   .irq_out       (irq_out)
);

// File: tb/tb_rpirq_status_top.sv
module tb_rpirq_status_top;
   localparam int CLK_P  = 10;
   localparam int ADDR_W = 8;
   localparam int DATA_W = 32;
   localparam int ERR_W  = 3;
   localparam int SLOT_W = 6;
   localparam logic [ADDR_W-1:0] RA = 8'h40;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [3:0]        intx_msg = '0;
   logic              intx_disable = 1'b0;
   logic [ERR_W-1:0]  err_status = '0;
   logic [ERR_W-1:0]  err_report_en = '0;
   logic              pme_int_en = 1'b0;
   logic              pme_status = 1'b0;
   logic              hp_int_en = 1'b0;
   logic [SLOT_W-1:0] slot_status = '0;
   logic [SLOT_W-1:0] slot_notify_en = '0;
   logic              pm_pme_en = 1'b0;
   logic              lbw_int_en = 1'b0;
   logic              lbw_status = 1'b0;
   logic              bwm_int_en = 1'b0;
   logic              bwm_status = 1'b0;
   logic              leq_int_en = 1'b0;
   logic              leq_req = 1'b0;
   logic              bus_rd = 1'b0;
   logic              bus_wr = 1'b0;
   logic [ADDR_W-1:0] bus_addr = '0;
   logic [DATA_W-1:0] bus_wdata = '0;
   logic [DATA_W-1:0] bus_rdata;
   logic              irq_out;

   int n_chk = 0;
   int n_fail = 0;
   logic [DATA_W-1:0] exp_q[$];
   string             tag_q[$];

   always #(CLK_P/2) clk = ~clk;

   rpirq_status_top #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_ADDR(RA),
                      .ERR_W(ERR_W), .SLOT_W(SLOT_W)) dut (.*);

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic check(input string tag, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
      end
   endtask

   // driver: issue a read and push what it must return
   task automatic do_read(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] exp, input string tag);
      bus_rd   = 1'b1;
      bus_addr = a;
      exp_q.push_back(exp);
      tag_q.push_back(tag);
      tick();
      bus_rd = 1'b0;
   endtask

   task automatic do_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
      bus_wr    = 1'b1;
      bus_addr  = a;
      bus_wdata = d;
      tick();
      bus_wr    = 1'b0;
      bus_wdata = '0;
   endtask

   // monitor: compare read data in the cycle after each read strobe
   initial begin
      forever begin
         logic seen;
         @(posedge clk);
         seen = bus_rd;
         @(negedge clk);
         if (seen) begin
            if (exp_q.size() == 0) begin
               check("monitor-underflow", 32'h1, 32'h0);
            end else begin
               logic [DATA_W-1:0] e;
               string t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               check(t, bus_rdata, e);
            end
         end
      end
   end

   initial begin
      #(CLK_P * 100000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      tick();
      // R1
      check("R1 irq after reset", {31'b0, irq_out}, 32'h0);
      do_read(RA, 32'h0, "R1 status after reset");

      // R2 and R12: INTC strobe, lag of irq
      intx_msg = 4'b0100;
      tick();
      intx_msg = 4'b0000;
      check("R12 irq lags status", {31'b0, irq_out}, 32'h0);
      do_read(RA, 32'h4, "R2 INTC sticky");
      check("R12 irq high", {31'b0, irq_out}, 32'h1);
      do_read(RA + 8'h1, 32'h0, "R13 foreign read is zero");
      do_write(RA, 32'hFFFF_FFFB);
      do_read(RA, 32'h4, "R9 zero data bit keeps status");
      do_write(RA + 8'h4, 32'h4);
      do_read(RA, 32'h4, "R9 foreign write ignored");
      do_write(RA, 32'h4);
      do_read(RA, 32'h0, "R2 cleared by write 1");
      check("R12 irq low", {31'b0, irq_out}, 32'h0);

      intx_msg = 4'b1111;
      tick();
      intx_msg = 4'b0000;
      do_read(RA, 32'hF, "R2 all four messages");
      // R10: set and clear together
      intx_msg = 4'b0010;
      do_write(RA, 32'hF);
      intx_msg = 4'b0000;
      do_read(RA, 32'h2, "R10 set beats clear");
      do_write(RA, 32'hFFFF_FFFF);
      do_read(RA, 32'h0, "R11 R9 clear all");

      // R3
      err_status = 3'b010; err_report_en = 3'b001;
      tick();
      do_read(RA, 32'h0, "R3 unmatched enable");
      err_report_en = 3'b011;
      tick();
      do_read(RA, 32'h10, "R3 matched pair");
      err_status = 3'b000;
      tick();
      do_read(RA, 32'h0, "R3 self clear");
      err_report_en = '0;

      // R4
      intx_disable = 1'b1; pme_int_en = 1'b1; pme_status = 1'b1;
      tick();
      do_read(RA, 32'h0, "R4 blocked by intx_disable");
      intx_disable = 1'b0;
      tick();
      do_read(RA, 32'h20, "R4 set");
      do_write(RA, 32'h20);
      do_read(RA, 32'h20, "R10 R4 held condition reasserts");
      pme_status = 1'b0;
      tick();
      do_read(RA, 32'h0, "R4 self clear");
      pme_int_en = 1'b0;

      // R5
      hp_int_en = 1'b1; slot_status = 6'b000100;
      tick();
      do_read(RA, 32'h0, "R5 notify disabled");
      slot_notify_en = 6'b000100;
      tick();
      do_read(RA, 32'h40, "R5 set");
      slot_status = '0;
      tick();
      do_read(RA, 32'h0, "R5 self clear");
      hp_int_en = 1'b0;

      // R6
      pm_pme_en = 1'b1; slot_notify_en = 6'b111111;
      tick();
      slot_status = 6'b000001;
      tick();
      do_read(RA, 32'h80, "R6 rising edge sets");
      do_write(RA, 32'h80);
      do_read(RA, 32'h0, "R6 steady level does not reset");
      slot_status = 6'b000011;
      tick();
      do_read(RA, 32'h80, "R6 new edge sets");
      slot_status = '0;
      tick();
      do_read(RA, 32'h0, "R6 self clear");
      pm_pme_en = 1'b0; slot_notify_en = '0;

      // R7
      intx_disable = 1'b1; bwm_int_en = 1'b1; bwm_status = 1'b1;
      tick();
      do_read(RA, 32'h0, "R7 blocked by intx_disable");
      bwm_int_en = 1'b0; bwm_status = 1'b0; intx_disable = 1'b0;
      lbw_int_en = 1'b1; lbw_status = 1'b1;
      tick();
      lbw_int_en = 1'b0; lbw_status = 1'b0;
      do_read(RA, 32'h100, "R7 bit 8 sticky");
      bwm_int_en = 1'b1; bwm_status = 1'b1;
      tick();
      bwm_int_en = 1'b0; bwm_status = 1'b0;
      do_read(RA, 32'h300, "R7 bit 9 sticky");
      do_write(RA, 32'h300);
      do_read(RA, 32'h0, "R7 cleared");

      // R8
      intx_disable = 1'b1; leq_int_en = 1'b1; leq_req = 1'b1;
      tick();
      leq_int_en = 1'b0; leq_req = 1'b0; intx_disable = 1'b0;
      do_read(RA, 32'h400, "R8 not gated, sticky");
      do_write(RA, 32'h400);
      do_read(RA, 32'h0, "R8 cleared");

      tick();
      tick();
      check("queue drained", exp_q.size(), 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule